// File: doc/BRIEF.md
# Triple DES Coprocessor

This block is a cipher engine that sits on a CPU's byte-wide peripheral register bus. Software fills two 64-bit keys and one 64-bit block one byte at a time. It then writes a control byte that selects encryption or decryption and starts the engine. The engine runs the two-key triple DES sequence. It computes one Feistel round per clock, with one load step and one output step around each of the three DES passes. When it has finished, it leaves the result in the block register, where software reads it back byte by byte.

In the encrypt direction the three passes are: DES encipher under key A, DES decipher under key B, DES encipher under key A. The decrypt direction runs the reverse: decipher under A, encipher under B, decipher under A. If both keys are equal, the whole operation reduces to single DES. Software sees two pointers, one for key bytes and one for block bytes. Each pointer advances on every access. A control bit sets both pointers back to zero, and the block pointer also returns to zero by itself when an operation completes.

Top module: `tdes_coproc`

## Requirements
- R1: After reset, `busy` and `done` are 0, the status register reads 0, and the block register reads back as all-zero bytes.
- R2: Writes to address 1 fill key A bytes 0..7 and then key B bytes 0..7. Byte 0 is the most significant byte of each key. The key pointer wraps back to key A byte 0 after the sixteenth write.
- R3: Writes and reads at address 2 access block bytes 0..7, with byte 0 the most significant byte. Each access advances a 3-bit pointer that wraps from 7 to 0.
- R4: With control bit 1 clear, the operation produces DES_enc_A(DES_dec_B(DES_enc_A(block))) using standard DES. When key A equals key B, this equals single DES encryption.
- R5: With control bit 1 set, the operation produces DES_dec_A(DES_enc_B(DES_dec_A(block))). This is the inverse of R4 for the same key pair.
- R6: A write to address 0 with bit 0 set starts the operation. `busy` is then high for exactly 54 clock cycles. `done` rises as `busy` falls, stays high, and is cleared by the next start.
- R7: A write to address 0 with bit 2 set, issued while idle, returns both the key pointer and the block pointer to 0.
- R8: While `busy` is high, writes to addresses 0, 1 and 2 have no effect on the keys, the block, the pointers or the running operation.
- R9: When an operation completes, the block pointer is 0, so the result reads out from byte 0 whatever the pointer held at the start.
- R10: Reads at address 3 return {6'b0, done, busy}. Reads at addresses 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sfrWr | input | 1 | Register write strobe |
| sfrRd | input | 1 | Register read strobe (advances the block pointer at address 2) |
| sfrAddr | input | 2 | Register address: 0 control, 1 key, 2 block, 3 status |
| sfrWdata | input | 8 | Write data byte |
| sfrRdata | output | 8 | Read data byte, combinational from address and pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation completed |

## Verification
The hardest case to reach from the ports is a bus access that arrives while the engine is running. If such an access leaked through, it would show up only later, as a wrong key byte or a shifted pointer on the next operation. The stimulus issues key, block and control writes, including a restart request and a pointer clear, during a busy window. It then checks that the result is still the known answer, and it loads the next operation's keys without clearing the pointers first. Known single-DES vectors (equal keys) pin down the round datapath. A distinct-key encrypt followed by a decrypt of its own output exercises the middle pass under key B.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  localparam int BYTE_W    = 8;
  localparam int BLK_W     = 64;
  localparam int HALF_W    = BLK_W / 2;
  localparam int CD_W      = 56;
  localparam int CD_HALF   = CD_W / 2;
  localparam int SUBKEY_W  = 48;
  localparam int ROUNDS    = 16;
  localparam int STAGES    = 3;
  localparam int BLK_BYTES = BLK_W / BYTE_W;
  localparam int KPTR_W    = $clog2(2 * BLK_BYTES);
  localparam int DPTR_W    = $clog2(BLK_BYTES);
  localparam int RIDX_W    = $clog2(ROUNDS);
  localparam int ADDR_W    = 2;
  localparam int OP_CYCLES = STAGES * (ROUNDS + 2);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic              load;
    logic              round;
    logic              finish;
    logic              useKeyB;
    logic              inverse;
    logic [RIDX_W-1:0] roundIdx;
  } dpStrobe_t;

  localparam int P_TAB [32] = '{16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
                                2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  localparam int PC1_TAB [56] = '{57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
                                  10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
                                  63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
                                  14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  localparam int PC2_TAB [48] = '{14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
                                  23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
                                  41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
                                  44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Each box: 64 nibbles, row-major (row = outer bits, column = inner bits), first entry in the MSBs.
  localparam logic [255:0] SBOX_TAB [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };

  // Source bit (1-based, MSB first) feeding output position i of the initial permutation.
  function automatic int ipSource(input int i);
    int row, col;
    row = i / 8;
    col = i % 8;
    return (row < 4) ? (58 + 2 * row - 8 * col) : (57 + 2 * (row - 4) - 8 * col);
  endfunction

  function automatic logic [BLK_W-1:0] initPerm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ipSource(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] finalPerm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-ipSource(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] expandHalf(input logic [HALF_W-1:0] r);
    logic [SUBKEY_W-1:0] y;
    y = '0;
    for (int g = 0; g < 8; g++)
      for (int j = 0; j < 6; j++)
        y[SUBKEY_W-1-(6*g+j)] = r[HALF_W-(((4*g+j+HALF_W-1) % HALF_W)+1)];
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] roundPerm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    y = '0;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_TAB[i]];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] keyChoice1(input logic [BLK_W-1:0] k);
    logic [CD_W-1:0] y;
    y = '0;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[BLK_W-PC1_TAB[i]];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] keyChoice2(input logic [CD_W-1:0] cd);
    logic [SUBKEY_W-1:0] y;
    y = '0;
    for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = cd[CD_W-PC2_TAB[i]];
    return y;
  endfunction

  function automatic logic [3:0] sboxLookup(input int box, input logic [5:0] x);
    int idx;
    idx = int'({x[5], x[0], x[4:1]});
    return SBOX_TAB[box][255-4*idx -: 4];
  endfunction

  function automatic int shiftOf(input logic [RIDX_W-1:0] idx);
    return (idx == 4'd0 || idx == 4'd1 || idx == 4'd8 || idx == 4'd15) ? 1 : 2;
  endfunction

  function automatic logic [CD_HALF-1:0] rotLeft(input logic [CD_HALF-1:0] x, input int n);
    return (n == 1) ? {x[CD_HALF-2:0], x[CD_HALF-1]} : {x[CD_HALF-3:0], x[CD_HALF-1:CD_HALF-2]};
  endfunction

  function automatic logic [CD_HALF-1:0] rotRight(input logic [CD_HALF-1:0] x, input int n);
    return (n == 1) ? {x[0], x[CD_HALF-1:1]} : {x[1:0], x[CD_HALF-1:2]};
  endfunction

endpackage

// File: rtl/tdes_datapath.sv
module tdes_datapath
  import tdes_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           st,
  input  logic                keyWe,
  input  logic [KPTR_W-1:0]   keyIdx,
  input  logic                dataWe,
  input  logic [DPTR_W-1:0]   dataIdx,
  input  logic [BYTE_W-1:0]   wrByte,
  output logic [BYTE_W-1:0]   rdByte
);

  logic [BLK_W-1:0]    keyA, keyB, blkQ;
  logic [HALF_W-1:0]   lQ, rQ;
  logic [CD_W-1:0]     cdQ, cdUse, cdNext;
  logic [SUBKEY_W-1:0] subKey, mixBits;
  logic [HALF_W-1:0]   sOut, fOut;
  int                  shAmt, shBack;

  always_comb begin
    shAmt  = shiftOf(st.roundIdx);
    shBack = shiftOf(4'(ROUNDS - 1) - st.roundIdx);
    if (st.inverse) begin
      cdUse  = cdQ;
      cdNext = {rotRight(cdQ[CD_W-1:CD_HALF], shBack), rotRight(cdQ[CD_HALF-1:0], shBack)};
    end else begin
      cdUse  = {rotLeft(cdQ[CD_W-1:CD_HALF], shAmt), rotLeft(cdQ[CD_HALF-1:0], shAmt)};
      cdNext = cdUse;
    end
    subKey  = keyChoice2(cdUse);
    mixBits = expandHalf(rQ) ^ subKey;
  end

  for (genvar g = 0; g < 8; g++) begin : g_sbox
    assign sOut[HALF_W-1-4*g -: 4] = sboxLookup(g, mixBits[SUBKEY_W-1-6*g -: 6]);
  end

  assign fOut = roundPerm(sOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyA <= '0;
      keyB <= '0;
      blkQ <= '0;
      lQ   <= '0;
      rQ   <= '0;
      cdQ  <= '0;
    end else begin
      if (keyWe) begin
        if (keyIdx[KPTR_W-1]) keyB[BLK_W-1-BYTE_W*int'(keyIdx[KPTR_W-2:0]) -: BYTE_W] <= wrByte;
        else                  keyA[BLK_W-1-BYTE_W*int'(keyIdx[KPTR_W-2:0]) -: BYTE_W] <= wrByte;
      end
      if (dataWe) blkQ[BLK_W-1-BYTE_W*int'(dataIdx) -: BYTE_W] <= wrByte;
      if (st.load) begin
        {lQ, rQ} <= initPerm(blkQ);
        cdQ      <= keyChoice1(st.useKeyB ? keyB : keyA);
      end
      if (st.round) begin
        lQ  <= rQ;
        rQ  <= lQ ^ fOut;
        cdQ <= cdNext;
      end
      if (st.finish) blkQ <= finalPerm({rQ, lQ});
    end
  end

  assign rdByte = blkQ[BLK_W-1-BYTE_W*int'(dataIdx) -: BYTE_W];

endmodule

// File: rtl/tdes_ctrl.sv
module tdes_ctrl
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWr,
  input  logic              sfrRd,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [2:0]        ctrlBits,
  output dpStrobe_t         st,
  output logic              keyWe,
  output logic [KPTR_W-1:0] keyIdx,
  output logic              dataWe,
  output logic [DPTR_W-1:0] dataIdx,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ROUND, S_FINISH} state_t;

  state_t            state;
  logic [1:0]        stageCnt;
  logic [RIDX_W-1:0] roundCnt;
  logic              decMode;
  logic              ctrlWr, dataRd, startReq, ptrClr, lastStage, opEnd;

  assign busy      = (state != S_IDLE);
  assign ctrlWr    = sfrWr && sfrAddr == ADDR_CTRL && !busy;
  assign keyWe     = sfrWr && sfrAddr == ADDR_KEY  && !busy;
  assign dataWe    = sfrWr && sfrAddr == ADDR_DATA && !busy;
  assign dataRd    = sfrRd && sfrAddr == ADDR_DATA && !busy;
  assign startReq  = ctrlWr && ctrlBits[0];
  assign ptrClr    = ctrlWr && ctrlBits[2];
  assign lastStage = (stageCnt == 2'(STAGES - 1));
  assign opEnd     = (state == S_FINISH) && lastStage;

  always_comb begin
    st          = '0;
    st.load     = (state == S_LOAD);
    st.round    = (state == S_ROUND);
    st.finish   = (state == S_FINISH);
    st.useKeyB  = (stageCnt == 2'd1);
    st.inverse  = decMode ^ (stageCnt == 2'd1);
    st.roundIdx = roundCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      stageCnt <= '0;
      roundCnt <= '0;
      decMode  <= 1'b0;
      done     <= 1'b0;
      keyIdx   <= '0;
      dataIdx  <= '0;
    end else begin
      if (ptrClr)     keyIdx <= '0;
      else if (keyWe) keyIdx <= keyIdx + 1'b1;

      if (ptrClr || opEnd)     dataIdx <= '0;
      else if (dataWe || dataRd) dataIdx <= dataIdx + 1'b1;

      unique case (state)
        S_IDLE: if (startReq) begin
          state    <= S_LOAD;
          stageCnt <= '0;
          roundCnt <= '0;
          decMode  <= ctrlBits[1];
          done     <= 1'b0;
        end
        S_LOAD: state <= S_ROUND;
        S_ROUND: begin
          if (roundCnt == RIDX_W'(ROUNDS - 1)) begin
            roundCnt <= '0;
            state    <= S_FINISH;
          end else begin
            roundCnt <= roundCnt + 1'b1;
          end
        end
        S_FINISH: begin
          if (lastStage) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            stageCnt <= stageCnt + 1'b1;
            state    <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tdes_coproc.sv
module tdes_coproc
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWr,
  input  logic              sfrRd,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [BYTE_W-1:0] sfrWdata,
  output logic [BYTE_W-1:0] sfrRdata,
  output logic              busy,
  output logic              done
);

  dpStrobe_t         dpSt;
  logic              keyWe, dataWe;
  logic [KPTR_W-1:0] keyIdx;
  logic [DPTR_W-1:0] dataIdx;
  logic [BYTE_W-1:0] dataByte;

  tdes_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sfrWr    (sfrWr),
    .sfrRd    (sfrRd),
    .sfrAddr  (sfrAddr),
    .ctrlBits (sfrWdata[2:0]),
    .st       (dpSt),
    .keyWe    (keyWe),
    .keyIdx   (keyIdx),
    .dataWe   (dataWe),
    .dataIdx  (dataIdx),
    .busy     (busy),
    .done     (done)
  );

  tdes_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (dpSt),
    .keyWe   (keyWe),
    .keyIdx  (keyIdx),
    .dataWe  (dataWe),
    .dataIdx (dataIdx),
    .wrByte  (sfrWdata),
    .rdByte  (dataByte)
  );

  always_comb begin
    unique case (sfrAddr)
      ADDR_DATA: sfrRdata = dataByte;
      ADDR_STAT: sfrRdata = {6'b0, done, busy};
      default:   sfrRdata = '0;
    endcase
  end

endmodule

// File: rtl/tdes_checker.sv
module tdes_checker
  import tdes_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sfrWr,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic [2:0]        ctrlBits,
  input logic              busy,
  input logic              done,
  input logic [2:0]        stFlags,
  input logic [KPTR_W-1:0] keyIdx,
  input logic [DPTR_W-1:0] dataIdx
);

  logic [7:0] busyCnt;
  logic       ctrlWrIdle;

  assign ctrlWrIdle = !busy && sfrWr && sfrAddr == ADDR_CTRL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 8'd1;
    else           busyCnt <= '0;
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stFlags));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrIdle && ctrlBits[0]) |=> (busy && !done));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == 8'(OP_CYCLES)));

  p_done_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));

  p_key_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(keyIdx));

  p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrIdle && ctrlBits[2]) |=> (keyIdx == '0 && dataIdx == '0));

  p_ptr_home_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (dataIdx == '0));

endmodule

bind tdes_coproc tdes_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sfrWr    (sfrWr),
  .sfrAddr  (sfrAddr),
  .ctrlBits (sfrWdata[2:0]),
  .busy     (busy),
  .done     (done),
  .stFlags  ({dpSt.load, dpSt.round, dpSt.finish}),
  .keyIdx   (keyIdx),
  .dataIdx  (dataIdx)
);

// File: tb/sim_tdes_coproc.sv
module sim_tdes_coproc;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_KEY = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sfrWr = 1'b0, sfrRd = 1'b0;
  logic [1:0] sfrAddr = 2'd0;
  logic [7:0] sfrWdata = 8'd0;
  logic [7:0] sfrRdata;
  logic       busy, done;

  int checks = 0, fails = 0;
  int opCount = 0, resultsTaken = 0;
  logic [63:0] lastResult = '0;
  logic [63:0] expQ[$];
  bit          useQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdes_coproc u0 (
    .clk(clk), .rstN(rstN), .sfrWr(sfrWr), .sfrRd(sfrRd), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrWr = 1'b1; sfrAddr = a; sfrWdata = d;
    @(negedge clk);
    sfrWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sfrRd = 1'b1; sfrAddr = a;
    #1 d = sfrRdata;
    @(negedge clk);
    sfrRd = 1'b0;
  endtask

  task automatic readBlock(output logic [63:0] b);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      busRead(A_DATA, v);
      b[63-8*i -: 8] = v;
    end
  endtask

  task automatic loadKeys(input logic [63:0] ka, input logic [63:0] kb);
    for (int i = 0; i < 8; i++) busWrite(A_KEY, ka[63-8*i -: 8]);
    for (int i = 0; i < 8; i++) busWrite(A_KEY, kb[63-8*i -: 8]);
  endtask

  task automatic loadBlock(input logic [63:0] b);
    for (int i = 0; i < 8; i++) busWrite(A_DATA, b[63-8*i -: 8]);
  endtask

  // Driver: pushes the expected result, runs the operation, waits for the monitor.
  task automatic runOp(input logic [63:0] ka, input logic [63:0] kb, input logic [63:0] blk,
                       input bit dec, input logic [63:0] exp, input bit useExp,
                       input string tag, input int skew, input bit noisy);
    logic [7:0] v;
    int cyc;
    expQ.push_back(exp); useQ.push_back(useExp); tagQ.push_back(tag);
    opCount++;
    loadKeys(ka, kb);
    loadBlock(blk);
    for (int i = 0; i < skew; i++) busRead(A_DATA, v);
    busWrite(A_CTRL, {6'b0, dec, 1'b1});
    chk("R6 done cleared by start", {63'b0, done}, 64'd0);
    if (noisy) begin
      busRead(A_STAT, v);
      chk("R10 status while busy", {56'b0, v}, 64'h1);
      for (int i = 0; i < 3; i++) busWrite(A_KEY, 8'hA5);
      for (int i = 0; i < 2; i++) busWrite(A_DATA, 8'h5A);
      busWrite(A_CTRL, {5'b0, 1'b1, ~dec, 1'b1});
      while (busy) @(negedge clk);
    end else begin
      cyc = 0;
      while (busy) begin cyc++; @(negedge clk); end
      chk("R6 busy length", 64'(cyc), 64'd54);
    end
    wait (resultsTaken == opCount);
  endtask

  // Monitor: on each completion reads the result and compares with the queue head.
  initial begin
    logic prevDone;
    logic [63:0] res, exp;
    bit use1;
    string tag;
    prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !prevDone && expQ.size() > 0) begin
        readBlock(res);
        lastResult = res;
        exp = expQ.pop_front(); use1 = useQ.pop_front(); tag = tagQ.pop_front();
        if (use1) chk(tag, res, exp);
        resultsTaken++;
      end
      prevDone = done;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [63:0] b, fwd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state
    chk("R1 busy after reset", {63'b0, busy}, 64'd0);
    chk("R1 done after reset", {63'b0, done}, 64'd0);
    busRead(A_STAT, v); chk("R1 R10 status after reset", {56'b0, v}, 64'd0);
    busRead(A_CTRL, v); chk("R10 control reads zero", {56'b0, v}, 64'd0);
    busRead(A_KEY, v);  chk("R10 key reads zero", {56'b0, v}, 64'd0);
    busWrite(A_CTRL, 8'h04);
    readBlock(b); chk("R1 block reads zero", b, 64'd0);

    // R3: data pointer wraps, byte 0 is MSB
    busWrite(A_CTRL, 8'h04);
    for (int i = 1; i <= 9; i++) busWrite(A_DATA, 8'(8'h11 * i));
    busWrite(A_CTRL, 8'h04);
    readBlock(b); chk("R3 wrap and order", b, 64'h9922334455667788);

    // R7: clear returns pointer to byte 0
    for (int i = 0; i < 3; i++) busWrite(A_DATA, 8'hC0);
    busWrite(A_CTRL, 8'h04);
    busRead(A_DATA, v); chk("R7 pointer clear", {56'b0, v}, 64'hC0);
    busWrite(A_CTRL, 8'h04);

    // R4 / R2: equal keys give single DES
    runOp(64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 1'b0,
          64'h85E813540F0AB405, 1'b1, "R4 R2 encrypt vector 1", 0, 1'b0);
    chk("R6 done held", {63'b0, done}, 64'd1);
    busRead(A_STAT, v); chk("R10 status when done", {56'b0, v}, 64'h2);

    // R5: decrypt direction
    runOp(64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, 1'b1,
          64'h0123456789ABCDEF, 1'b1, "R5 decrypt vector 1", 0, 1'b0);

    // R4 / R9: all-zero key, pointer left at 3 before start
    runOp(64'h0, 64'h0, 64'h0, 1'b0, 64'h8CA64DE9C1B123A7, 1'b1,
          "R4 R9 zero vector with pointer skew", 3, 1'b0);
    runOp(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b0,
          64'h7359B2163E4EDC58, 1'b1, "R4 ones vector", 0, 1'b0);

    // R8: bus traffic during busy is ignored; next keys load from pointer 0
    runOp(64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 1'b0,
          64'h85E813540F0AB405, 1'b1, "R8 writes while busy ignored", 0, 1'b1);
    runOp(64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, 1'b1,
          64'h0123456789ABCDEF, 1'b1, "R8 R2 key pointer intact after busy", 0, 1'b0);

    // R4 / R5: distinct keys, decrypt inverts encrypt
    runOp(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h4E6F772069732074, 1'b0,
          64'h0, 1'b0, "R4 distinct-key encrypt", 0, 1'b0);
    fwd = lastResult;
    checks++;
    if (fwd === 64'h4E6F772069732074) begin
      fails++;
      $display("FAIL R4 ciphertext equals plaintext actual=%h expected=not %h", fwd, 64'h4E6F772069732074);
    end
    runOp(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, fwd, 1'b1,
          64'h4E6F772069732074, 1'b1, "R5 distinct-key round trip", 0, 1'b0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule